// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block sits behind a byte-wide command stream from a host FIFO. It turns that stream into reads and writes on a small internal bank of 8-bit registers. The upper four bits of each command byte select an operation and the lower four bits carry a nibble of payload. The host builds an 8-bit register address from two nibble commands. It builds a write value the same way: one command latches the low nibble, and a second command supplies the high nibble and commits the byte. A read command sends one byte back on a byte-wide response stream. A flag in the read command can step the address on, so a run of registers can be read back to back. A second write opcode also steps the address after each write, so one address setup can fill a run of registers.

The bank has four kinds of register. Address 0x00 is a fixed identity register. Address 0x01 is a scratch register. Address 0x02 holds the acquisition mode and status. A parameterised group of general configuration registers starts at address 0x10, and their contents drive an output bus. Writes to the mode address take command values that start acquisition, stop it, or enable sample-memory readout. Reading the mode address returns a status byte that includes a sticky trigger flag.

Top module: `nibcmd_top`

## Requirements
- R1: The command opcode sits in bits 7:4 and the payload nibble in bits 3:0. The opcodes are: 0x2 address low, 0x3 address high, 0x4 data low, 0x5 write and hold address, 0x6 write and advance address, 0x8 read. Every other opcode is unknown.
- R2: An address-low command replaces address bits 3:0 with the payload. An address-high command replaces bits 7:4. All address increments wrap from 0xFF to 0x00.
- R3: A data-low command stores the payload in the nibble latch. A write-and-hold command writes {payload, latch} to the addressed register and leaves the address unchanged.
- R4: A write-and-advance command writes {payload, latch} to the addressed register, then adds one to the address. Repeated data-low and write-and-advance pairs therefore fill successive registers.
- R5: Each accepted read command raises rd_valid for exactly one cycle, in the cycle after the command is taken. rd_data carries the content of the current address at the time of the read. No other command raises rd_valid.
- R6: A read command with payload bit 0 set adds one to the address after the read. With bit 0 clear, the address stays the same.
- R7: Address 0x00 always reads 0xA6 and ignores writes.
- R8: Address 0x01 reads back the last value written to it.
- R9: A write of 0x0D to address 0x02 starts acquisition, clears readout enable and clears the trigger flag. A write of 0x11 stops acquisition. A write of 0x02 enables readout. Any other value written there is ignored.
- R10: Reading address 0x02 returns a status byte: bit 0 is acquisition running, bit 1 is readout enabled, bit 5 is the trigger flag, and all other bits are 0. The trigger flag is set by trig_hit while acquisition is running and stays set until the next start.
- R11: Unknown opcodes change no state and produce no response.
- R12: Reset clears the address, the nibble latch, the scratch register, the general registers, the mode state and rd_valid to 0.
- R13: The GP_COUNT general registers sit at addresses GP_BASE upwards (0x10 by default) and are readable and writable. All other unmapped addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_byte | input | 8 | Command byte: opcode in 7:4, payload in 3:0 |
| trig_hit | input | 1 | Trigger event from the capture logic |
| rd_valid | output | 1 | Response byte valid, one cycle per read |
| rd_data | output | 8 | Response byte |
| acq_run | output | 1 | Acquisition running |
| mem_rd_en | output | 1 | Sample-memory readout enabled |
| cfg_regs | output | GP_COUNT*8 | General register contents, register i in bits 8i+7:8i |

## Verification
The assertions check the command-level rules on every cycle. These are the one-cycle read response and its absence for other commands, the address changes for address loads, holds and read advances, the stillness of all state under unknown opcodes, the fixed identity value, and the condition for the trigger flag to rise. Only the bench's scenarios can show the values that depend on the register map. Examples are scratch readback, the fill pattern in the general registers, writes to unmapped addresses being dropped, address wrap, the mode transitions, and the state left after a reset in mid-stream.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = 4;

  localparam logic [3:0] OPC_ADDR_LO = 4'h2;
  localparam logic [3:0] OPC_ADDR_HI = 4'h3;
  localparam logic [3:0] OPC_DATA_LO = 4'h4;
  localparam logic [3:0] OPC_WR_HOLD = 4'h5;
  localparam logic [3:0] OPC_WR_ADV  = 4'h6;
  localparam logic [3:0] OPC_READ    = 4'h8;

  localparam logic [AW-1:0] ADR_IDENT   = 8'h00;
  localparam logic [AW-1:0] ADR_SCRATCH = 8'h01;
  localparam logic [AW-1:0] ADR_MODE    = 8'h02;

  localparam logic [DW-1:0] IDENT_VALUE  = 8'hA6;
  localparam logic [DW-1:0] MODE_START   = 8'h0D;
  localparam logic [DW-1:0] MODE_STOP    = 8'h11;
  localparam logic [DW-1:0] MODE_READOUT = 8'h02;

  typedef struct packed {
    logic          ld_alo;
    logic          ld_ahi;
    logic          ld_dlo;
    logic          wr;
    logic          wr_adv;
    logic          rd;
    logic          rd_adv;
    logic [NW-1:0] arg;
  } cmd_dec_t;

  function automatic logic [DW-1:0] join_byte(input logic [NW-1:0] hi,
                                              input logic [NW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] bump_addr(input logic [AW-1:0] a);
    return AW'(a + 1'b1);
  endfunction

  function automatic logic [DW-1:0] status_byte(input logic run,
                                                input logic mem,
                                                input logic trig);
    return {2'b00, trig, 3'b000, mem, run};
  endfunction

endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
  import nibcmd_pkg::*;
(
  input  logic     cmd_valid,
  input  logic [7:0] cmd_byte,
  output cmd_dec_t dec
);
  logic [3:0] opc;
  assign opc = cmd_byte[7:4];

  always_comb begin
    dec        = '0;
    dec.arg    = cmd_byte[3:0];
    if (cmd_valid) begin
      dec.ld_alo = (opc == OPC_ADDR_LO);
      dec.ld_ahi = (opc == OPC_ADDR_HI);
      dec.ld_dlo = (opc == OPC_DATA_LO);
      dec.wr     = (opc == OPC_WR_HOLD) || (opc == OPC_WR_ADV);
      dec.wr_adv = (opc == OPC_WR_ADV);
      dec.rd     = (opc == OPC_READ);
      dec.rd_adv = (opc == OPC_READ) && cmd_byte[0];
    end
  end
endmodule

// File: rtl/nibcmd_pointer.sv
module nibcmd_pointer
  import nibcmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_dec_t      dec,
  output logic [AW-1:0] addr_q,
  output logic [NW-1:0] nib_q,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (dec.ld_alo)
      addr_d = {addr_q[AW-1:NW], dec.arg};
    else if (dec.ld_ahi)
      addr_d = {dec.arg, addr_q[NW-1:0]};
    else if (dec.wr_adv || dec.rd_adv)
      addr_d = bump_addr(addr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      nib_q  <= '0;
    end else begin
      addr_q <= addr_d;
      if (dec.ld_dlo)
        nib_q <= dec.arg;
    end
  end

  assign wr_stb  = dec.wr;
  assign wr_data = join_byte(dec.arg, nib_q);
endmodule

// File: rtl/nibcmd_regbank.sv
module nibcmd_regbank
  import nibcmd_pkg::*;
#(
  parameter int            GP_COUNT = 8,
  parameter logic [7:0]    GP_BASE  = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   trig_hit,
  output logic [DW-1:0]          rd_byte,
  output logic                   run_q,
  output logic                   mem_q,
  output logic                   trig_q,
  output logic [GP_COUNT*DW-1:0] gp_flat
);
  logic          scratch_q;
  logic [DW-1:0] scratch_r;
  logic          mode_wr;
  logic          start_cmd;
  logic          stop_cmd;
  logic          readout_cmd;
  logic [GP_COUNT-1:0] gp_hit;

  assign scratch_q   = wr_stb && (addr == ADR_SCRATCH);
  assign mode_wr     = wr_stb && (addr == ADR_MODE);
  assign start_cmd   = mode_wr && (wr_data == MODE_START);
  assign stop_cmd    = mode_wr && (wr_data == MODE_STOP);
  assign readout_cmd = mode_wr && (wr_data == MODE_READOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_r <= '0;
      run_q     <= 1'b0;
      mem_q     <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      if (scratch_q)
        scratch_r <= wr_data;
      if (start_cmd) begin
        run_q <= 1'b1;
        mem_q <= 1'b0;
      end else if (stop_cmd) begin
        run_q <= 1'b0;
      end else if (readout_cmd) begin
        mem_q <= 1'b1;
      end
      if (start_cmd)
        trig_q <= 1'b0;
      else if (trig_hit && run_q)
        trig_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
    localparam logic [AW-1:0] SLOT = AW'(int'(GP_BASE) + g);
    logic [DW-1:0] r;
    assign gp_hit[g] = (addr == SLOT);
    always_ff @(posedge clk) begin
      if (!rst_n)
        r <= '0;
      else if (wr_stb && gp_hit[g])
        r <= wr_data;
    end
    assign gp_flat[g*DW +: DW] = r;
  end

  always_comb begin
    rd_byte = '0;
    if (addr == ADR_IDENT)
      rd_byte = IDENT_VALUE;
    else if (addr == ADR_SCRATCH)
      rd_byte = scratch_r;
    else if (addr == ADR_MODE)
      rd_byte = status_byte(run_q, mem_q, trig_q);
    else
      for (int i = 0; i < GP_COUNT; i++)
        if (gp_hit[i])
          rd_byte = gp_flat[i*DW +: DW];
  end
endmodule

// File: rtl/nibcmd_top.sv
module nibcmd_top
  import nibcmd_pkg::*;
#(
  parameter int         GP_COUNT = 8,
  parameter logic [7:0] GP_BASE  = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_byte,
  input  logic                 trig_hit,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  output logic                 acq_run,
  output logic                 mem_rd_en,
  output logic [GP_COUNT*8-1:0] cfg_regs
);
  cmd_dec_t      dec;
  logic [AW-1:0] addr_q;
  logic [NW-1:0] nib_q;
  logic          wr_stb;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_byte;
  logic          trig_q;

  nibcmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .dec       (dec)
  );

  nibcmd_pointer u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec     (dec),
    .addr_q  (addr_q),
    .nib_q   (nib_q),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );

  nibcmd_regbank #(.GP_COUNT(GP_COUNT), .GP_BASE(GP_BASE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .addr     (addr_q),
    .wr_data  (wr_data),
    .trig_hit (trig_hit),
    .rd_byte  (rd_byte),
    .run_q    (acq_run),
    .mem_q    (mem_rd_en),
    .trig_q   (trig_q),
    .gp_flat  (cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= dec.rd;
      if (dec.rd)
        rd_data <= rd_byte;
    end
  end
endmodule

// File: rtl/nibcmd_chk.sv
module nibcmd_chk
  import nibcmd_pkg::*;
#(
  parameter int GP_COUNT = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [7:0]             cmd_byte,
  input logic                   trig_hit,
  input logic                   rd_valid,
  input logic [7:0]             rd_data,
  input logic                   acq_run,
  input logic                   mem_rd_en,
  input logic [GP_COUNT*8-1:0]  cfg_regs,
  input logic [7:0]             addr_q,
  input logic [3:0]             nib_q,
  input logic                   trig_q
);
  logic [3:0] op;
  logic       is_rd;
  logic       is_unk;
  assign op     = cmd_byte[7:4];
  assign is_rd  = cmd_valid && (op == OPC_READ);
  assign is_unk = cmd_valid && !(op inside {OPC_ADDR_LO, OPC_ADDR_HI, OPC_DATA_LO,
                                            OPC_WR_HOLD, OPC_WR_ADV, OPC_READ});

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);

  // R5
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);

  // R6
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cmd_byte[0]) |=> (addr_q == 8'($past(addr_q) + 8'd1)));

  // R2
  addr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OPC_ADDR_LO) |=>
      (addr_q[3:0] == $past(cmd_byte[3:0])) && (addr_q[7:4] == $past(addr_q[7:4])));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OPC_WR_HOLD) |=> $stable(addr_q));

  // R11
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_unk |=> ($stable(addr_q) && $stable(nib_q) && $stable(cfg_regs) &&
                $stable(acq_run) && $stable(mem_rd_en) && !rd_valid));

  // R7
  ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && addr_q == ADR_IDENT) |=> (rd_data == IDENT_VALUE));

  // R10
  trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> $past(trig_hit && acq_run));
endmodule

bind nibcmd_top nibcmd_chk #(.GP_COUNT(GP_COUNT)) u_nibcmd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .trig_hit  (trig_hit),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .acq_run   (acq_run),
  .mem_rd_en (mem_rd_en),
  .cfg_regs  (cfg_regs),
  .addr_q    (addr_q),
  .nib_q     (nib_q),
  .trig_q    (trig_q)
);

// File: tb/test_nibcmd_top.sv
`timescale 1ns/1ps
module test_nibcmd_top;
  localparam int GP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic          trig_hit = 1'b0;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          acq_run;
  logic          mem_rd_en;
  logic [GP*8-1:0] cfg_regs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  nibcmd_top #(.GP_COUNT(GP), .GP_BASE(8'h10)) i_nibcmd_top (
    .clk, .rst_n, .cmd_valid, .cmd_byte, .trig_hit,
    .rd_valid, .rd_data, .acq_run, .mem_rd_en, .cfg_regs
  );

  // {expect response, expected byte, command}
  localparam int NV = 55;
  localparam logic [16:0] VEC [NV] = '{
    17'h1A680,                                  // R7 R1 ident read
    17'h00021, 17'h00045, 17'h00055, 17'h15580, // R3 R8 scratch 0x55
    17'h0004A, 17'h0005A, 17'h1AA80,            // R8 scratch 0xAA
    17'h00020, 17'h0004F, 17'h0005F, 17'h1A680, // R7 ident write ignored
    17'h00020, 17'h00031,                       // R2 address 0x10
    17'h00043, 17'h00061, 17'h00044, 17'h00062, // R4 fill 0x10,0x11
    17'h00020, 17'h00031,
    17'h11381, 17'h12481, 17'h10080,            // R6 R13 advancing reads
    17'h00021, 17'h00030, 17'h00047,
    17'h0000F, 17'h000A5, 17'h000F3,            // R11 unknown opcodes
    17'h00050, 17'h10780,                       // R11 latch kept 0x7
    17'h0002F, 17'h0003F, 17'h00041, 17'h00051, // R13 write 0xFF dropped
    17'h10081, 17'h1A680,                       // R2 wrap to 0x00
    17'h00022, 17'h00030, 17'h10080,            // R10 idle status
    17'h0004D, 17'h00050, 17'h10180,            // R9 start
    17'h00041, 17'h00051, 17'h10080,            // R9 stop
    17'h00042, 17'h00050, 17'h10280,            // R9 readout
    17'h00043, 17'h00050, 17'h10280,            // R9 other value ignored
    17'h0004D, 17'h00050, 17'h10180             // R9 start clears readout
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic v, output logic [7:0] d);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    v = rd_valid;
    d = rd_data;
  endtask

  task automatic expect_read(input logic [7:0] b, input logic [7:0] exp, input string req);
    logic v;
    logic [7:0] d;
    send(b, v, d);
    check(v && d == exp, req, {v, d}, {1'b1, exp});
  endtask

  task automatic expect_quiet(input logic [7:0] b, input string req);
    logic v;
    logic [7:0] d;
    send(b, v, d);
    check(!v, req, v, 0);
  endtask

  task automatic pulse_trig();
    trig_hit = 1'b1;
    @(negedge clk);
    trig_hit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!rd_valid && !acq_run && !mem_rd_en && cfg_regs == '0, "R12",
          {rd_valid, acq_run, mem_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16])
        expect_read(VEC[i][7:0], VEC[i][15:8], "R5 vector read");
      else
        expect_quiet(VEC[i][7:0], "R5 vector quiet");
    end

    // R4 general registers filled in sequence
    check(cfg_regs[15:0] == 16'h2413, "R4", cfg_regs[15:0], 16'h2413);
    // R9 run and readout pins
    check(acq_run && !mem_rd_en, "R9", {acq_run, mem_rd_en}, 2'b10);

    // R10 trigger while running, address is 0x02
    pulse_trig();
    expect_read(8'h80, 8'h21, "R10 trig set");
    expect_quiet(8'h41, "R9"); expect_quiet(8'h51, "R9");
    expect_read(8'h80, 8'h20, "R10 trig sticky after stop");
    expect_quiet(8'h4D, "R9"); expect_quiet(8'h50, "R9");
    expect_read(8'h80, 8'h01, "R9 start clears trig");
    expect_quiet(8'h41, "R9"); expect_quiet(8'h51, "R9");
    pulse_trig();
    expect_read(8'h80, 8'h00, "R10 trig ignored when stopped");

    // R12 reset in mid-stream
    expect_quiet(8'h21, "R2"); expect_quiet(8'h30, "R2");
    expect_quiet(8'h49, "R3"); expect_quiet(8'h59, "R3");
    expect_read(8'h80, 8'h99, "R8");
    cmd_byte = 8'h80; cmd_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!rd_valid && !acq_run && cfg_regs == '0, "R12 in reset",
          {rd_valid, acq_run}, 0);
    rst_n = 1'b1;
    expect_read(8'h80, 8'hA6, "R12 address cleared");
    expect_quiet(8'h21, "R12");
    expect_read(8'h80, 8'h00, "R12 scratch cleared");
    expect_quiet(8'h5C, "R12");
    expect_read(8'h80, 8'hC0, "R12 latch cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule